// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block turns single-clock requests into correctly timed access cycles on an external asynchronous static RAM of 64K words by 16 bits. The memory's control pins are all active low. A requester offers a word address, a write flag, write data and a per-byte mask on a valid/ready handshake. The controller then walks the memory through a fixed sequence of phases. Each phase lasts a whole number of clocks, chosen so that the memory's minimum access, write-pulse and data-setup times are met. Read results come back with a single-clock valid pulse.

The data bus is split into an outgoing word, an incoming word and a drive-enable, so the tri-state pad stays outside the block. During a write, the controller keeps its drivers off for a turnaround interval after write enable falls, so the memory has time to release the bus. The address is set up one clock before any strobe falls and is held one clock after the strobes rise. Phase lengths default to the ceiling of each timing figure divided by the clock period, with a minimum of one clock.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_dq_oe is 0, and mem_cs_n, mem_we_n, mem_oe_n and both bits of mem_be_n are 1.
- R2: A request is taken only on a clock where req_ready is 1. req_ready then stays 0 until the access has completed. While req_ready is 1, mem_cs_n and mem_we_n are 1 and mem_dq_oe is 0.
- R3: For a read with a non-zero mask, the clock after acceptance is a setup clock: mem_addr carries the request address and all strobes are high. Next come READ_CYCLES clocks with mem_cs_n=0, mem_oe_n=0 and mem_we_n=1. Then comes one hold clock with all strobes high.
- R4: Read data is sampled on the last clock of the read phase. rsp_valid is 1 for exactly the hold clock and carries that data. A lane whose mask bit is 0 returns zero. Mask bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R5: While a strobe is active, mem_be_n equals the bitwise inverse of the request mask: mem_be_n[0] is the lower-byte select and mem_be_n[1] the upper. Whenever mem_cs_n is 1, mem_be_n is all ones.
- R6: For a write with a non-zero mask, one setup clock is followed by TURN_CYCLES+WE_CYCLES clocks with mem_cs_n=0 and mem_we_n=0, then one hold clock with both high. mem_oe_n stays 1 throughout.
- R7: mem_dq_oe is 0 for the first TURN_CYCLES clocks of the write strobe. It is 1 for the following WE_CYCLES clocks and for the hold clock, with mem_dq_out equal to the request data. mem_dq_oe is never 1 while mem_oe_n is 0.
- R8: mem_addr holds the request address unchanged from the setup clock through the hold clock.
- R9: A request with an all-zero mask never lowers any strobe and finishes in one clock after acceptance. A read of this kind still gives rsp_valid with data zero.
- R10: Writes never raise rsp_valid.
- R11: The default phase lengths are ceil(t / CLK_PS) clocks, with a minimum of one: 10000 ps of access time for the read phase, and 6000 ps each for turnaround and data setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Active-high byte mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-clock read-data pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte selects, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench drives a memory model in which read data only becomes valid one clock before the end of the read phase, and unselected lanes carry a filler byte. Early sampling and missing lane masking both therefore show up in rsp_rdata. The writes use a full mask, lower only, upper only and zero. A later full read then separates correct lane merging from whole-word overwrites and from writes that were never blocked. Reads with single-lane masks show whether the unselected lane is zeroed. A second address shows that no access aliases onto another.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RD, ST_WTURN, ST_WDATA, ST_HOLD
  } phase_e;

  // ceiling of a timing figure over the clock period, never below one clock
  function automatic int unsigned ps_to_cycles(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // current phase ends on the clock where the count reaches zero
  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_decode.sv
`timescale 1ns/1ps
module sram_lane_decode #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANES-1:0]        mask,
  input  logic                    active,
  input  logic [LANES*LANE_W-1:0] rd_bus,
  output logic [LANES-1:0]        be_n,
  output logic [LANES*LANE_W-1:0] rd_masked
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_n[l] = ~(active & mask[l]);
    assign rd_masked[l*LANE_W +: LANE_W] = mask[l] ? rd_bus[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl import sram_lane_pkg::*; #(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LANES       = 2,
  parameter int unsigned READ_CYCLES = ps_to_cycles(10000, CLK_PS),
  parameter int unsigned TURN_CYCLES = ps_to_cycles(6000, CLK_PS),
  parameter int unsigned WE_CYCLES   = ps_to_cycles(6000, CLK_PS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned LANE_W = DATA_W / LANES;
  localparam int unsigned PH_MAX = max3(READ_CYCLES, TURN_CYCLES, WE_CYCLES);
  localparam int unsigned CNT_W  = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

  phase_e              state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic [LANES-1:0]    mask_q;
  logic                wr_q;

  // named internal events
  logic accept, strobe, rd_sample, wr_drive, t_done, t_load;
  logic [CNT_W-1:0] t_val;
  logic [DATA_W-1:0] rd_masked;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign strobe    = (state_q == ST_RD) || (state_q == ST_WTURN) || (state_q == ST_WDATA);
  assign rd_sample = (state_q == ST_RD) && t_done;
  assign wr_drive  = (state_q == ST_WDATA) || ((state_q == ST_HOLD) && wr_q && (|mask_q));

  assign t_load = (state_q == ST_SETUP) || ((state_q == ST_WTURN) && t_done);
  always_comb begin
    if (state_q == ST_SETUP)
      t_val = wr_q ? CNT_W'(TURN_CYCLES - 1) : CNT_W'(READ_CYCLES - 1);
    else
      t_val = CNT_W'(WE_CYCLES - 1);
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  sram_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .mask(mask_q), .active(strobe), .rd_bus(mem_dq_in),
    .be_n(mem_be_n), .rd_masked(rd_masked)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = (|req_mask) ? ST_SETUP : ST_HOLD;
      ST_SETUP: state_d = wr_q ? ST_WTURN : ST_RD;
      ST_RD:    if (t_done) state_d = ST_HOLD;
      ST_WTURN: if (t_done) state_d = ST_WDATA;
      ST_WDATA: if (t_done) state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
        wr_q    <= req_write;
        rdata_q <= '0;
      end else if (rd_sample) begin
        rdata_q <= rd_masked;
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_HOLD) && !wr_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_cs_n   = !strobe;
  assign mem_we_n   = !((state_q == ST_WTURN) || (state_q == ST_WDATA));
  assign mem_oe_n   = !(state_q == ST_RD);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = wr_drive;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && !mem_dq_oe)); // R2
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n); // R6
  AST_OE_EXCL_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_TURN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n || $past(!mem_cs_n)) |-> $stable(mem_addr)); // R8
  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (&mem_be_n)); // R5
endmodule

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
  localparam int CLK_PERIOD = 5;
  localparam int CLK_PS_TB  = CLK_PERIOD * 1000;
  localparam int RD_C   = (10000 + CLK_PS_TB - 1) / CLK_PS_TB;
  localparam int TURN_C = (6000 + CLK_PS_TB - 1) / CLK_PS_TB;
  localparam int WE_C   = (6000 + CLK_PS_TB - 1) / CLK_PS_TB;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready, rsp_valid;
  logic [15:0] req_addr = 0, req_wdata = 0, rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic [1:0] req_mask = 0, mem_be_n;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0, fails = 0, contention = 0, rd_age = 0;
  logic [15:0] model [0:255];
  logic [15:0] shadow [0:255];

  always #(CLK_PERIOD/2.0) clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: data valid only from the second read clock, filler elsewhere
  always @(posedge clk) rd_age <= (!mem_cs_n && !mem_oe_n) ? rd_age + 1 : 0;
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (!mem_cs_n && mem_we_n && !mem_oe_n && !mem_be_n[l] && rd_age >= RD_C - 1)
        mem_dq_in[l*8 +: 8] = model[mem_addr[7:0]][l*8 +: 8];
      else
        mem_dq_in[l*8 +: 8] = 8'hEE;
    end
  end
  always @(negedge clk) begin
    if (!mem_cs_n && mem_we_n && !mem_oe_n && mem_dq_oe) contention++;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe)
      for (int l = 0; l < 2; l++)
        if (!mem_be_n[l]) model[mem_addr[7:0]][l*8 +: 8] = mem_dq_out[l*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_dq_oe == 0, "R1", {req_ready, rsp_valid, mem_dq_oe}, 3'b100);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mem_cs_n == 1, "R1", {req_ready, mem_cs_n}, 2'b11);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    issue(1, a, d, m);
    // setup clock
    chk(mem_cs_n && mem_we_n && !mem_dq_oe && mem_addr == a, "R6", {mem_cs_n, mem_we_n, mem_dq_oe, mem_addr}, {3'b110, a});
    chk(req_ready == 0, "R2", req_ready, 0);
    for (int i = 0; i < TURN_C; i++) begin
      @(negedge clk);
      chk(!mem_cs_n && !mem_we_n && mem_oe_n, "R6", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b001);
      chk(mem_dq_oe == 0, "R7", mem_dq_oe, 0);
      chk(mem_be_n == ~m, "R5", mem_be_n, ~m);
      chk(mem_addr == a, "R8", mem_addr, a);
    end
    for (int i = 0; i < WE_C; i++) begin
      @(negedge clk);
      chk(!mem_cs_n && !mem_we_n && mem_oe_n, "R6", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b001);
      chk(mem_dq_oe && mem_dq_out == d, "R7", {mem_dq_oe, mem_dq_out}, {1'b1, d});
      chk(req_ready == 0, "R2", req_ready, 0);
    end
    @(negedge clk); // hold clock
    chk(mem_cs_n && mem_we_n && (&mem_be_n), "R6", {mem_cs_n, mem_we_n, mem_be_n}, 4'hF);
    chk(mem_dq_oe == 1 && mem_addr == a, "R7", {mem_dq_oe, mem_addr}, {1'b1, a});
    chk(rsp_valid == 0, "R10", rsp_valid, 0);
    @(negedge clk);
    chk(req_ready == 1 && !mem_dq_oe && rsp_valid == 0, "R2", {req_ready, mem_dq_oe, rsp_valid}, 3'b100);
    for (int l = 0; l < 2; l++) if (m[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic t_read(input logic [15:0] a, input logic [1:0] m);
    logic [15:0] exp;
    int low;
    exp = shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
    low = 0;
    @(negedge clk);
    issue(0, a, 16'h0, m);
    chk(mem_cs_n && mem_oe_n && mem_addr == a && !req_ready, "R3", {mem_cs_n, mem_oe_n, req_ready, mem_addr}, {3'b110, a});
    for (int i = 0; i < RD_C; i++) begin
      @(negedge clk);
      if (!mem_cs_n) low++;
      chk(!mem_cs_n && !mem_oe_n && mem_we_n, "R3", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b001);
      chk(mem_be_n == ~m, "R5", mem_be_n, ~m);
      chk(rsp_valid == 0, "R4", rsp_valid, 0);
    end
    @(negedge clk);
    chk(low == RD_C, "R11", low, RD_C);
    chk(mem_cs_n && mem_oe_n && mem_addr == a, "R8", {mem_cs_n, mem_oe_n, mem_addr}, {2'b11, a});
    chk(rsp_valid && rsp_rdata == exp, "R4", {rsp_valid, rsp_rdata}, {1'b1, exp});
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R4", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_zero(input bit wr, input logic [15:0] a);
    @(negedge clk);
    issue(wr, a, 16'hFFFF, 2'b00);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready, "R9",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);
    chk(rsp_valid == !wr, "R9", rsp_valid, !wr);
    if (!wr) chk(rsp_rdata == 0, "R9", rsp_rdata, 0);
    @(negedge clk);
    chk(req_ready && mem_cs_n, "R9", {req_ready, mem_cs_n}, 2'b11);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin model[i] = 0; shadow[i] = 0; end
    t_reset();
    t_write(16'h1203, 16'hA5C3, 2'b11);
    t_read (16'h1203, 2'b11);
    t_write(16'h1203, 16'h7E3C, 2'b01);
    t_read (16'h1203, 2'b11);
    t_write(16'h1203, 16'h99AB, 2'b10);
    t_read (16'h1203, 2'b01);
    t_read (16'h1203, 2'b10);
    t_zero (1, 16'h1203);
    t_read (16'h1203, 2'b11);
    t_zero (0, 16'h1203);
    t_write(16'hA05C, 16'h0F0F, 2'b11);
    t_read (16'hA05C, 2'b11);
    t_read (16'h1203, 2'b11);
    chk(contention == 0, "R7", contention, 0);
    chk(shadow[8'h03] == 16'h993C, "R5", shadow[8'h03], 16'h993C);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule